// File: doc/BRIEF.md
# Mode-Selectable Programmable Frequency Divider

This block divides a fast oscillator clock by a programmed ratio and emits a single-cycle pulse each time a division period completes. The pulse feeds a phase comparator that also sees a reference clock. A 16-bit data word sets the ratio. Two mode inputs choose how that word is read:
- the coarse mode drops the four lowest data bits and uses the twelve upper bits directly;
- the fine mode uses all sixteen bits as the ratio;
- the doubling mode uses all sixteen bits and divides by twice that value.

The ratio comes from the mode and data inputs as they stand at a terminal count, so a new setting never cuts a period short. An inhibit input parks the divider. It holds the counter in an idle state with the output low, and counting restarts from a full period when inhibit is released.

Top module: `fdiv_prog_divider`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is low. Take a reset released at a falling clock edge. Counting from that edge, the first pulse is seen at the (N+1)th falling edge, where N is the current ratio.
- R2: With `dbl_mode`=1, whatever the value of `full_res`, consecutive pulses are 2*S clocks apart. S is the 16-bit `div_data` value, with bit 15 as the MSB.
- R3: With `dbl_mode`=0 and `full_res`=1, consecutive pulses are S clocks apart, where S is the whole 16-bit `div_data`.
- R4: With `dbl_mode`=0 and `full_res`=0, the ratio is `div_data[15:4]`. Bits [3:0] have no effect on the pulse spacing.
- R5: An all-zero data field means the largest setting. That is 65536 in the fine and doubling modes and 4096 in the coarse mode.
- R6: A set value below the mode minimum is raised to that minimum. The minimum is 256 in the fine and doubling modes and 4 in the coarse mode.
- R7: A change of `div_data` or of the mode inputs during a period leaves that period's length unchanged. The following period uses the new ratio.
- R8: Each pulse on `div_pulse` is high for exactly one clock cycle.
- R9: While `inhibit` is high, `div_pulse` stays low and counting stops. Take an inhibit released at a falling edge. Counting from that edge, the first pulse comes at the (N+1)th falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| div_data | input | 16 | Programmed divider value |
| dbl_mode | input | 1 | Divide by twice the set value |
| full_res | input | 1 | Use all 16 bits (when not doubling); 0 selects the coarse mode |
| inhibit | input | 1 | Stops the divider and forces the output low |
| div_pulse | output | 1 | One-cycle pulse per completed division period |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a period. It can only be seen by timing the period in which the change happens against the period that follows. The stimulus first locks onto a pulse and lets a fixed number of cycles pass. It then changes the data word and counts edges to the next pulse and to the one after it. The all-zero field in the fine mode sets the longest ratio. That case is reached by switching the data word to zero within a running short period, so only one long period has to be waited out.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  typedef enum logic [1:0] {
    FDIV_COARSE = 2'd0,
    FDIV_FINE   = 2'd1,
    FDIV_DOUBLE = 2'd2
  } fdiv_mode_e;

  function automatic fdiv_mode_e fdiv_pick_mode(input logic dbl, input logic full);
    if (dbl)       return FDIV_DOUBLE;
    else if (full) return FDIV_FINE;
    else           return FDIV_COARSE;
  endfunction

endpackage

// File: rtl/fdiv_mode_decode.sv
module fdiv_mode_decode #(
  parameter int DATA_W       = 16,
  parameter int COARSE_SHIFT = 4,
  parameter int FULL_MIN     = 256,
  parameter int COARSE_MIN   = 4,
  parameter int RATIO_W      = DATA_W + 2
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic               dbl_i,
  input  logic               full_i,
  output logic [RATIO_W-1:0] ratio_o
);
  import fdiv_pkg::*;

  localparam int COARSE_W    = DATA_W - COARSE_SHIFT;
  localparam int FULL_SPAN   = 1 << DATA_W;
  localparam int COARSE_SPAN = 1 << COARSE_W;

  function automatic logic [RATIO_W-1:0] fine_set(input logic [DATA_W-1:0] d);
    logic [RATIO_W-1:0] s;
    s = (d == '0) ? RATIO_W'(FULL_SPAN) : RATIO_W'(d);
    if (s < RATIO_W'(FULL_MIN)) s = RATIO_W'(FULL_MIN);
    return s;
  endfunction

  function automatic logic [RATIO_W-1:0] coarse_set(input logic [COARSE_W-1:0] c);
    logic [RATIO_W-1:0] s;
    s = (c == '0) ? RATIO_W'(COARSE_SPAN) : RATIO_W'(c);
    if (s < RATIO_W'(COARSE_MIN)) s = RATIO_W'(COARSE_MIN);
    return s;
  endfunction

  fdiv_mode_e mode;
  assign mode = fdiv_pick_mode(dbl_i, full_i);

  always_comb begin
    case (mode)
      FDIV_DOUBLE: ratio_o = fine_set(data_i) << 1;
      FDIV_FINE:   ratio_o = fine_set(data_i);
      default:     ratio_o = coarse_set(data_i[DATA_W-1:COARSE_SHIFT]);
    endcase
  end

endmodule

// File: rtl/fdiv_down_counter.sv
module fdiv_down_counter #(
  parameter int RATIO_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inhibit_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               load_o,
  output logic               tc_o,
  output logic               pulse_o
);
  logic [RATIO_W-1:0] cnt_q;
  logic               armed_q;

  assign tc_o   = armed_q && (cnt_q == '0) && !inhibit_i;
  assign load_o = !inhibit_i && (!armed_q || cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pulse_o <= 1'b0;
    end else if (inhibit_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pulse_o <= 1'b0;
    end else if (load_o) begin
      cnt_q   <= ratio_i - RATIO_W'(1);
      armed_q <= 1'b1;
      pulse_o <= armed_q;
    end else begin
      cnt_q   <= cnt_q - RATIO_W'(1);
      pulse_o <= 1'b0;
    end
  end

  // R7: a reload always takes the ratio present at the terminal edge
  a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (cnt_q == $past(ratio_i) - RATIO_W'(1)));

  // R8: no two pulses back to back
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R9: inhibit parks the counter and silences the output
  a_r9_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> (!pulse_o && !armed_q));

  // R1: the first pulse after arming needs a full period
  a_r1_no_early_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !inhibit_i) |=> !pulse_o);

endmodule

// File: rtl/fdiv_prog_divider.sv
module fdiv_prog_divider #(
  parameter int DATA_W       = 16,
  parameter int COARSE_SHIFT = 4,
  parameter int FULL_MIN     = 256,
  parameter int COARSE_MIN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] div_data,
  input  logic              dbl_mode,
  input  logic              full_res,
  input  logic              inhibit,
  output logic              div_pulse
);
  localparam int RATIO_W     = DATA_W + 2;
  localparam int COARSE_SPAN = 1 << (DATA_W - COARSE_SHIFT);

  logic [RATIO_W-1:0] ratio_w;
  logic               load_w;
  logic               tc_w;

  fdiv_mode_decode #(
    .DATA_W(DATA_W), .COARSE_SHIFT(COARSE_SHIFT),
    .FULL_MIN(FULL_MIN), .COARSE_MIN(COARSE_MIN), .RATIO_W(RATIO_W)
  ) u_decode (
    .data_i (div_data),
    .dbl_i  (dbl_mode),
    .full_i (full_res),
    .ratio_o(ratio_w)
  );

  fdiv_down_counter #(.RATIO_W(RATIO_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .inhibit_i(inhibit),
    .ratio_i  (ratio_w),
    .load_o   (load_w),
    .tc_o     (tc_w),
    .pulse_o  (div_pulse)
  );

  // R8: a pulse follows exactly the terminal-count cycle
  a_r8_pulse_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
    tc_w |=> div_pulse);

  // R6: full-range modes never divide below the floor
  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_mode || full_res) |-> (ratio_w >= RATIO_W'(FULL_MIN)));

  // R2: doubling always gives an even ratio
  a_r2_even_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_mode |-> !ratio_w[0]);

  // R4: coarse ratio stays in its range
  a_r4_coarse_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_mode && !full_res) |->
      (ratio_w <= RATIO_W'(COARSE_SPAN) && ratio_w >= RATIO_W'(COARSE_MIN)));

  // R7: a terminal count coincides with a reload
  a_r7_tc_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    tc_w |-> load_w);

endmodule

// File: tb/sim_fdiv_prog_divider.sv
module sim_fdiv_prog_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_data = 16'd0;
  logic        dbl_mode = 1'b0;
  logic        full_res = 1'b0;
  logic        inhibit = 1'b0;
  logic        div_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fdiv_prog_divider u0 (
    .clk(clk), .rst_n(rst_n), .div_data(div_data),
    .dbl_mode(dbl_mode), .full_res(full_res),
    .inhibit(inhibit), .div_pulse(div_pulse)
  );

  function automatic int want_ratio(int d, bit dbl, bit full);
    int v;
    if (dbl || full) begin
      v = (d == 0) ? 65536 : d;
      v = (v < 256) ? 256 : v;
      return dbl ? v * 2 : v;
    end
    v = d / 16;
    if (v == 0) v = 4096;
    return (v < 4) ? 4 : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int d, bit dbl, bit full);
    div_data = d[15:0];
    dbl_mode = dbl;
    full_res = full;
  endtask

  task automatic next_pulse();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!div_pulse && guard < 140000);
  endtask

  // from a negedge where the pulse is high, count edges to the next pulse
  task automatic span(output int n, input string req);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) check(!div_pulse, {req, "/R8 width"}, int'(div_pulse), 0);
    end while (!div_pulse && n < 140000);
  endtask

  task automatic period_case(int d, bit dbl, bit full, string req);
    int n;
    int e;
    set_cfg(d, dbl, full);
    next_pulse();
    e = want_ratio(d, dbl, full);
    span(n, req);
    check(n == e, req, n, e);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int k;
    void'($urandom(32'd2024));
    // R1: reset state and first period
    set_cfg(300, 1'b0, 1'b1);
    repeat (4) begin
      @(negedge clk);
      check(!div_pulse, "R1 reset low", int'(div_pulse), 0);
    end
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < 2000);
    check(n == 301, "R1 first pulse", n, 301);

    // R3 fine mode
    period_case(1000, 1'b0, 1'b1, "R3");
    period_case(256, 1'b0, 1'b1, "R3");
    // R2 doubling, either fine bit
    period_case(300, 1'b1, 1'b0, "R2");
    period_case(300, 1'b1, 1'b1, "R2");
    // R4 coarse mode, low bits ignored
    period_case(16'h0123, 1'b0, 1'b0, "R4");
    period_case(16'h012F, 1'b0, 1'b0, "R4");
    // R6 floors
    period_case(5, 1'b0, 1'b1, "R6");
    period_case(10, 1'b1, 1'b0, "R6");
    period_case(16'h0020, 1'b0, 1'b0, "R6");
    // R5 zero field
    period_case(16'h000F, 1'b0, 1'b0, "R5");
    period_case(0, 1'b0, 1'b1, "R5");

    // R7 mid-period change
    set_cfg(1000, 1'b0, 1'b1);
    next_pulse();
    next_pulse();
    repeat (100) @(negedge clk);
    set_cfg(400, 1'b0, 1'b1);
    n = 100;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < 5000);
    check(n == 1000, "R7 old period", n, 1000);
    span(n, "R7");
    check(n == 400, "R7 new period", n, 400);

    // R9 inhibit
    set_cfg(500, 1'b0, 1'b1);
    next_pulse();
    repeat (7) @(negedge clk);
    inhibit = 1'b1;
    repeat (50) begin
      @(negedge clk);
      check(!div_pulse, "R9 inhibit low", int'(div_pulse), 0);
    end
    inhibit = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < 5000);
    check(n == 501, "R9 restart", n, 501);

    // random mix
    for (int i = 0; i < 25; i++) begin
      k = $urandom_range(0, 2);
      if (k == 0) period_case($urandom_range(0, 65535), 1'b0, 1'b0, "R4 rand");
      else if (k == 1) period_case($urandom_range(1, 700), 1'b0, 1'b1, "R3 rand");
      else period_case($urandom_range(1, 700), 1'b1, 1'($urandom_range(0, 1)), "R2 rand");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule